// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block is one general-purpose I/O port of up to eight pins. Each pin has a direction bit and an output latch bit. A per-pin mode input chooses whether the pin serves the port itself or an on-chip peripheral. In port mode the latch drives the pin and the direction bit gates the driver. In peripheral mode the peripheral supplies both the value and the output enable.

Software reaches the port through a small word-wide register bus. It has a write strobe, a two-bit address and a combinational read path. There are three registers: direction, output latch, and a read-only sampled pin level. The pin level passes through a two-flop synchronizer.

Two instance parameters shape each port:
- A mask of implemented bit positions. Absent pins never drive, and their bits read as zero.
- A mask of output-only pins. On these pins the direction bit does not gate the driver, but the bit is still kept as plain read/write storage.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register (address 0) reads back the implemented mask, which is 0x003F by default. The latch (address 1) reads 0x0000. In port mode `pin_out` is 0, and `pin_oe` is high only on the output-only pins (0x0F by default).
- R2: For an implemented pin that is not output-only and has `port_mode`=1: direction bit 0 sets `pin_oe` high and drives `pin_out` with the latch bit; direction bit 1 sets `pin_oe` low.
- R3: Reading address 1 returns the stored latch contents, whatever levels are present on `pin_in`.
- R4: Write data in bits 15:8, and in the bits of absent pins (bits 7:6 by default), is discarded. Those bits always read 0. Absent pins keep `pin_out` and `pin_oe` at 0.
- R5: An output-only pin (bits 3:0 by default) in port mode always has `pin_oe` high, whatever its direction bit. That direction bit still reads back as written.
- R6: A pin with `port_mode`=0 presents `alt_out` on `pin_out` and `alt_oe` on `pin_oe`.
- R7: Address 2 returns `pin_in` (implemented bits only) through two flops. A change made before clock edge n shows after edge n+1, not after edge n.
- R8: A write with `bus_wr`=1 takes effect at that clock edge and changes only the addressed register. Writes to address 2 or 3 change nothing, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 direction, 1 latch, 2 pin level, 3 unused |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| port_mode | input | 8 | Per pin: 1 port function, 0 peripheral function |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral drive requests |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |

## Verification
The pin multiplexer is tried with several input patterns:
- All pins in port mode, all pins in peripheral mode, and a half-and-half split. Together these separate the latch path from the peripheral path on each pin.
- Direction values that set the two fixed-function groups against each other. These show whether the output-only mask overrides the direction bit for pin control, and whether the bit is still kept as storage.
- Pin levels opposite to the latch contents. These show whether latch readback comes from storage or from the pins.
- All-ones writes, and writes to the read-only and unused addresses. These show whether absent bits stay absent and whether registers are independent.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    parameter int PORT_W = 8;
    parameter int BUS_W  = 16;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DIR = 2'd0;
    localparam logic [ADDR_W-1:0] A_LAT = 2'd1;
    localparam logic [ADDR_W-1:0] A_PIN = 2'd2;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] lat;
    } port_regs_t;

    typedef struct packed {
        logic [PORT_W-1:0] stage1;
        logic [PORT_W-1:0] stage2;
    } sync_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [PORT_W-1:0] dir_q,
    output logic [PORT_W-1:0] lat_q
);
    port_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr && addr == A_DIR) regs_d.dir = wdata[PORT_W-1:0] & IMPL_MASK;
        if (wr && addr == A_LAT) regs_d.lat = wdata[PORT_W-1:0] & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.dir <= IMPL_MASK;
            regs_q.lat <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_q = regs_q.dir;
    assign lat_q = regs_q.lat;
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync
    import gpio_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK = 8'h3F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] raw,
    output logic [PORT_W-1:0] level_q
);
    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.stage1 = raw & IMPL_MASK;
        sync_d.stage2 = sync_q.stage1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign level_q = sync_q.stage2;
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
    import gpio_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK  = 8'h3F,
    parameter logic [PORT_W-1:0] FIXED_MASK = 8'h0F
) (
    input  logic [PORT_W-1:0] dir,
    input  logic [PORT_W-1:0] lat,
    input  logic [PORT_W-1:0] mode,
    input  logic [PORT_W-1:0] alt_out,
    input  logic [PORT_W-1:0] alt_oe,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_pin
        if (!IMPL_MASK[i]) begin : g_absent
            assign pin_out[i] = 1'b0;
            assign pin_oe[i]  = 1'b0;
        end else if (FIXED_MASK[i]) begin : g_outonly
            assign pin_out[i] = mode[i] ? lat[i] : alt_out[i];
            assign pin_oe[i]  = mode[i] ? 1'b1   : alt_oe[i];
        end else begin : g_bidir
            assign pin_out[i] = mode[i] ? lat[i]  : alt_out[i];
            assign pin_oe[i]  = mode[i] ? ~dir[i] : alt_oe[i];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK  = 8'h3F,
    parameter logic [PORT_W-1:0] FIXED_MASK = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PORT_W-1:0] port_mode,
    input  logic [PORT_W-1:0] alt_out,
    input  logic [PORT_W-1:0] alt_oe,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe
);
    localparam int PAD_W = BUS_W - PORT_W;

    logic [PORT_W-1:0] dir_q, lat_q, level_q;

    gpio_regs #(.IMPL_MASK(IMPL_MASK)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .dir_q(dir_q), .lat_q(lat_q)
    );

    gpio_sync #(.IMPL_MASK(IMPL_MASK)) i_sync (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .level_q(level_q)
    );

    gpio_pinmux #(.IMPL_MASK(IMPL_MASK), .FIXED_MASK(FIXED_MASK)) i_mux (
        .dir(dir_q), .lat(lat_q), .mode(port_mode),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always_comb begin
        unique case (bus_addr)
            A_DIR:   bus_rdata = {{PAD_W{1'b0}}, dir_q};
            A_LAT:   bus_rdata = {{PAD_W{1'b0}}, lat_q};
            A_PIN:   bus_rdata = {{PAD_W{1'b0}}, level_q};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter logic [PORT_W-1:0] IMPL_MASK  = 8'h3F,
    parameter logic [PORT_W-1:0] FIXED_MASK = 8'h0F
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [PORT_W-1:0] port_mode,
    input logic [PORT_W-1:0] pin_oe,
    input logic [PORT_W-1:0] pin_out,
    input logic [PORT_W-1:0] dir_q,
    input logic [PORT_W-1:0] lat_q
);
    // R4: absent pins never drive
    a_r4_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | pin_out) & ~IMPL_MASK) == '0);

    // R4: absent bits never held in storage
    a_r4_no_absent_storage: assert property (@(posedge clk) disable iff (!rst_n)
        ((dir_q | lat_q) & ~IMPL_MASK) == '0);

    // R5: output-only pins in port mode always drive
    a_r5_fixed_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((port_mode & FIXED_MASK & IMPL_MASK) & ~pin_oe) == '0);

    // R8: latch write lands at the next edge
    a_r8_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_LAT) |=> lat_q == ($past(bus_wdata[PORT_W-1:0]) & IMPL_MASK));

    // R3/R8: latch holds without a latch write
    a_r3_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_LAT) |=> $stable(lat_q));

    // R8: direction holds without a direction write
    a_r8_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_DIR) |=> $stable(dir_q));
endmodule

bind gpio_port gpio_port_chk #(.IMPL_MASK(IMPL_MASK), .FIXED_MASK(FIXED_MASK)) i_chk (.*);

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  port_mode = 8'hFF;
    logic [7:0]  alt_out = '0;
    logic [7:0]  alt_oe = '0;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_port i_gpio_port (.*);

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        rd(2'd0, d); check("R1 dir reset", d, 16'h003F);
        rd(2'd1, d); check("R1 lat reset", d, 16'h0000);
        check("R1 oe reset", {8'h0, pin_oe}, 16'h000F);
        check("R1 out reset", {8'h0, pin_out}, 16'h0000);
    endtask

    task automatic t_direction();
        wr(2'd1, 16'h002A);
        wr(2'd0, 16'h000F);
        #1;
        check("R2 oe outputs", {8'h0, pin_oe}, 16'h003F);
        check("R2 out latch", {8'h0, pin_out}, 16'h002A);
        wr(2'd0, 16'h002F);
        #1;
        check("R2 pin5 input", {8'h0, pin_oe}, 16'h001F);
    endtask

    task automatic t_readback();
        logic [15:0] d;
        pin_in = 8'h15;
        repeat (3) @(negedge clk);
        rd(2'd1, d); check("R3 latch not pins", d, 16'h002A);
        rd(2'd2, d); check("R3 pin reg differs", d, 16'h0015);
    endtask

    task automatic t_absent();
        logic [15:0] d;
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'hFFFF);
        rd(2'd0, d); check("R4 dir masked", d, 16'h003F);
        rd(2'd1, d); check("R4 lat masked", d, 16'h003F);
        wr(2'd0, 16'hFFC0);
        rd(2'd0, d); check("R4 dir high writes dropped", d, 16'h0000);
        #1;
        check("R4 absent pins idle", {8'h0, pin_oe & 8'hC0}, 16'h0000);
        check("R4 absent out idle", {8'h0, pin_out & 8'hC0}, 16'h0000);
    endtask

    task automatic t_fixed();
        logic [15:0] d;
        wr(2'd0, 16'h0005);
        rd(2'd0, d); check("R5 dir storage", d, 16'h0005);
        check("R5 fixed oe", {8'h0, pin_oe}, 16'h003F);
        wr(2'd0, 16'h003F);
        #1;
        check("R5 fixed oe all dir 1", {8'h0, pin_oe}, 16'h000F);
    endtask

    task automatic t_periph();
        wr(2'd1, 16'h0000);
        wr(2'd0, 16'h0000);
        port_mode = 8'h00; alt_out = 8'hA5; alt_oe = 8'h5A;
        #1;
        check("R6 alt out", {8'h0, pin_out}, 16'h0025);
        check("R6 alt oe", {8'h0, pin_oe}, 16'h001A);
        port_mode = 8'h0F;
        #1;
        check("R6 mixed out", {8'h0, pin_out}, 16'h0020);
        check("R6 mixed oe", {8'h0, pin_oe}, 16'h001F);
        port_mode = 8'hFF; alt_out = '0; alt_oe = '0;
    endtask

    task automatic t_sync();
        logic [15:0] d;
        @(negedge clk);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'hFF;
        @(negedge clk);
        rd(2'd2, d); check("R7 one edge old", d, 16'h0000);
        @(negedge clk);
        rd(2'd2, d); check("R7 two edges new", d, 16'h003F);
    endtask

    task automatic t_isolation();
        logic [15:0] d;
        wr(2'd0, 16'h0011);
        wr(2'd1, 16'h0022);
        wr(2'd2, 16'h00FF);
        wr(2'd3, 16'h00FF);
        rd(2'd0, d); check("R8 dir kept", d, 16'h0011);
        rd(2'd1, d); check("R8 lat kept", d, 16'h0022);
        rd(2'd3, d); check("R8 addr3 zero", d, 16'h0000);
        wr(2'd1, 16'h0007);
        rd(2'd0, d); check("R8 dir unaffected", d, 16'h0011);
        rd(2'd1, d); check("R8 lat updated", d, 16'h0007);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction();
        t_readback();
        t_absent();
        t_fixed();
        t_periph();
        t_sync();
        t_isolation();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule